// File: doc/BRIEF.md
# Coprocessor Context-Save Responder

This block is the coprocessor side of a context-save handshake. A host reads a save register to begin saving the coprocessor's state. If the coprocessor's internal operation is still running, the read returns a not-ready code. The block then raises a suspend request so that the operation finishes or parks itself. On a later save read, once the operation has gone quiet, the block returns a format word that announces how many bytes of state follow. The host then reads an operand register once per 32-bit state word until the announced amount has been delivered, and the block drops back to idle.

A write to the control register with the abort bit set cancels any save in progress and returns the block to idle at once. The state words sit in a small store. A parallel load port fills that store for test. The state size is a parameter in bytes and must be a multiple of four. A size of zero makes the block answer with the empty format code and never enter a transfer.

Top module: `cp_save_responder`

## Requirements
- R1: After synchronous reset, `idle` is 1 and `suspend_req` is 0.
- R2: A save read (`rd_en`=1, `rd_sel`=2'b01) taken outside a transfer while `busy_in`=1 returns 32'h0100_0000 (not-ready, code 8'h01 in bits 31:24). From the next cycle `suspend_req`=1 and `idle`=0. Every further save read while `busy_in` stays 1 again returns not-ready, for any number of cycles.
- R3: A save read taken outside a transfer while `busy_in`=0 returns the format word {8'h1F, byte count[7:0], 16'h0000} (32'h1F10_0000 for 16 bytes). It clears `suspend_req` from the next cycle and starts a transfer at word 0.
- R4: During a transfer, each operand read (`rd_sel`=2'b10) returns the next state word in the same cycle, starting at word 0 and going upward.
- R5: The cycle after the operand read of the last word, `idle` is 1.
- R6: A control write (`wr_en`=1, `wr_sel`=2'b00) with `wr_data` bit 0 set aborts. From the next cycle `idle`=1 and `suspend_req`=0, from any state. An operand read in the same cycle still returns the current word, and a later save starts again at word 0.
- R7: A control write with bit 0 clear has no effect on a transfer in progress.
- R8: An operand read while no transfer is in progress returns 0 and leaves the state unchanged.
- R9: A save read during a transfer returns the valid format word again and does not move the word position.
- R10: With a state size of 0, a save read while `busy_in`=0 returns 32'h0000_0000 (empty code 8'h00), and `idle` stays or becomes 1.
- R11: A pulse on `test_load` loads state word i from `test_data[32*i+31 : 32*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read target: 01 save, 10 operand, others read 0 |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 control, others ignored |
| wr_data | input | 32 | Write data; bit 0 is the abort mask |
| busy_in | input | 1 | Internal operation still running |
| suspend_req | output | 1 | Ask the internal operation to suspend or complete |
| idle | output | 1 | No save in progress |
| test_load | input | 1 | Parallel load of the state store |
| test_data | input | 32*max(words,1) | State image for the parallel load |

## Verification
An abort write and an operand read can land in the same cycle, because the read and write strobes are independent. The bench provokes this in the middle of a transfer by raising both strobes together. It expects the read to return the word at the current position, and it expects `idle` one cycle later. A fresh save after that must deliver word 0 again, which shows that the abort, not the read, decided the next position.

// File: rtl/cpsv_pkg.sv
package cpsv_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_SAVE = 2'b01,
        SEL_OPND = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_SUSPEND = 2'b01,
        ST_XFER    = 2'b10
    } save_state_e;

    localparam logic [7:0] CODE_EMPTY     = 8'h00;
    localparam logic [7:0] CODE_NOT_READY = 8'h01;
    localparam logic [7:0] CODE_VALID     = 8'h1F;
    localparam int         ABORT_BIT      = 0;
    localparam int         WORD_W         = 32;

    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  length;
        logic [15:0] rsvd;
    } fmt_word_t;

    typedef struct packed {
        logic save_rd;
        logic opnd_rd;
        logic abort_wr;
    } bus_ev_t;

    function automatic fmt_word_t make_fmt(input logic [7:0] code, input logic [7:0] len);
        fmt_word_t f;
        f.code   = code;
        f.length = len;
        f.rsvd   = '0;
        return f;
    endfunction

    function automatic int words_of(input int bytes);
        return bytes / 4;
    endfunction

endpackage

// File: rtl/cpsv_decode.sv
module cpsv_decode
    import cpsv_pkg::*;
(
    input  logic        rd_en,
    input  logic [1:0]  rd_sel,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output bus_ev_t     ev
);

    always_comb begin
        ev.save_rd  = rd_en && (rd_sel == SEL_SAVE);
        ev.opnd_rd  = rd_en && (rd_sel == SEL_OPND);
        ev.abort_wr = wr_en && (wr_sel == SEL_CTRL) && wr_data[ABORT_BIT];
    end

endmodule

// File: rtl/cpsv_fsm.sv
module cpsv_fsm
    import cpsv_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              busy_in,
    output save_state_e       st_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              suspend_req
);

    localparam bit               HAS_STATE = (WORDS > 0);
    localparam logic [IDX_W-1:0] LAST_IDX  = (WORDS > 0) ? IDX_W'(WORDS - 1) : '0;

    save_state_e      st_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ev.save_rd) begin
                    if (busy_in) begin
                        st_d = ST_SUSPEND;
                    end else if (HAS_STATE) begin
                        st_d  = ST_XFER;
                        idx_d = '0;
                    end
                end
            end
            ST_SUSPEND: begin
                if (ev.save_rd && !busy_in) begin
                    st_d  = HAS_STATE ? ST_XFER : ST_IDLE;
                    idx_d = '0;
                end
            end
            ST_XFER: begin
                if (ev.opnd_rd) begin
                    if (idx_q == LAST_IDX) begin
                        st_d  = ST_IDLE;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = ST_IDLE;
                idx_d = '0;
            end
        endcase
        if (ev.abort_wr) begin
            st_d  = ST_IDLE;
            idx_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    assign suspend_req = (st_q == ST_SUSPEND);

    // R2
    suspend_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(suspend_req) |-> $past(ev.save_rd && busy_in));

    // R3
    leave_suspend_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(suspend_req) |-> $past(!busy_in || ev.abort_wr));

    generate
        if (WORDS == 0) begin : g_empty_chk
            // R10
            no_xfer_chk: assert property (@(posedge clk) disable iff (rst)
                st_q != ST_XFER);
        end
    endgenerate

endmodule

// File: rtl/cpsv_store.sv
module cpsv_store
    import cpsv_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int IDX_W  = 2,
    parameter int LOAD_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LOAD_W-1:0]  load_data,
    input  logic [IDX_W-1:0]   idx,
    output logic [WORD_W-1:0]  word
);

    generate
        if (WORDS == 0) begin : g_none
            assign word = '0;
        end else begin : g_mem
            logic [WORD_W-1:0] mem [WORDS];
            for (genvar i = 0; i < WORDS; i++) begin : g_word
                always_ff @(posedge clk) begin
                    if (rst) begin
                        mem[i] <= '0;
                    end else if (load) begin
                        mem[i] <= load_data[WORD_W*i +: WORD_W];
                    end
                end
            end
            assign word = mem[idx];
        end
    endgenerate

endmodule

// File: rtl/cpsv_rdmux.sv
module cpsv_rdmux
    import cpsv_pkg::*;
#(
    parameter int STATE_BYTES = 16
) (
    input  bus_ev_t            ev,
    input  logic               busy_in,
    input  save_state_e        st_q,
    input  logic [WORD_W-1:0]  word,
    output logic [WORD_W-1:0]  rd_data
);

    localparam bit HAS_STATE = (STATE_BYTES >= 4);

    fmt_word_t valid_fmt, nr_fmt, empty_fmt;

    always_comb begin
        valid_fmt = make_fmt(CODE_VALID, 8'(STATE_BYTES));
        nr_fmt    = make_fmt(CODE_NOT_READY, 8'h00);
        empty_fmt = make_fmt(CODE_EMPTY, 8'h00);
        rd_data   = '0;
        if (ev.save_rd) begin
            if (st_q == ST_XFER)    rd_data = valid_fmt;
            else if (busy_in)       rd_data = nr_fmt;
            else if (HAS_STATE)     rd_data = valid_fmt;
            else                    rd_data = empty_fmt;
        end else if (ev.opnd_rd && st_q == ST_XFER) begin
            rd_data = word;
        end
    end

endmodule

// File: rtl/cp_save_responder.sv
module cp_save_responder
    import cpsv_pkg::*;
#(
    parameter int STATE_BYTES = 16,
    localparam int WORDS  = STATE_BYTES / 4,
    localparam int LOAD_W = 32 * ((WORDS > 0) ? WORDS : 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              busy_in,
    output logic              suspend_req,
    output logic              idle,
    input  logic              test_load,
    input  logic [LOAD_W-1:0] test_data
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    bus_ev_t          ev;
    save_state_e      st_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      word;

    cpsv_decode u_decode (
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ev      (ev)
    );

    cpsv_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .busy_in     (busy_in),
        .st_q        (st_q),
        .idx_q       (idx_q),
        .suspend_req (suspend_req)
    );

    cpsv_store #(.WORDS(WORDS), .IDX_W(IDX_W), .LOAD_W(LOAD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load      (test_load),
        .load_data (test_data),
        .idx       (idx_q),
        .word      (word)
    );

    cpsv_rdmux #(.STATE_BYTES(STATE_BYTES)) u_rdmux (
        .ev      (ev),
        .busy_in (busy_in),
        .st_q    (st_q),
        .word    (word),
        .rd_data (rd_data)
    );

    assign idle = (st_q == ST_IDLE);

    // R2
    not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_SAVE && busy_in && st_q != ST_XFER)
            |-> rd_data == 32'h0100_0000);

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL && wr_data[0]) |=> (idle && !suspend_req));

    // R8
    opnd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_OPND && st_q != ST_XFER) |-> rd_data == 32'h0);

    // R8
    opnd_idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_OPND && st_q != ST_XFER) |=> $stable(st_q));

    // R9
    save_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_SAVE && st_q == ST_XFER && !(wr_en && wr_sel == SEL_CTRL && wr_data[0]))
            |=> ($stable(idx_q) && st_q == ST_XFER));

endmodule

// File: tb/test_cp_save_responder.sv
module test_cp_save_responder;

    localparam int BYTES = 16;
    localparam int NW    = BYTES / 4;
    localparam logic [31:0] FMT_VALID = {8'h1F, 8'(BYTES), 16'h0000};
    localparam logic [31:0] FMT_NR    = 32'h0100_0000;
    localparam logic [1:0]  S_SAVE = 2'b01, S_OPND = 2'b10, S_CTRL = 2'b00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_en = 1'b0, wr_en = 1'b0, busy_in = 1'b0, test_load = 1'b0;
    logic [1:0]  rd_sel = 2'b11, wr_sel = 2'b11;
    logic [31:0] wr_data = '0;
    logic [32*NW-1:0] test_data = '0;
    logic [31:0] rd_data;
    logic suspend_req, idle;

    logic z_rd_en = 1'b0, z_busy = 1'b0;
    logic [1:0] z_rd_sel = 2'b11;
    logic [31:0] z_rd_data;
    logic z_susp, z_idle;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    logic [31:0] pat [NW];

    always #10 clk = ~clk;

    cp_save_responder #(.STATE_BYTES(BYTES)) i_cp_save_responder (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .busy_in(busy_in),
        .suspend_req(suspend_req), .idle(idle), .test_load(test_load), .test_data(test_data)
    );

    cp_save_responder #(.STATE_BYTES(0)) i_zero (
        .clk(clk), .rst(rst), .rd_en(z_rd_en), .rd_sel(z_rd_sel), .rd_data(z_rd_data),
        .wr_en(1'b0), .wr_sel(2'b11), .wr_data(32'h0), .busy_in(z_busy),
        .suspend_req(z_susp), .idle(z_idle), .test_load(1'b0), .test_data(32'h0)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per read strobe, sampled mid-low-phase
    always begin
        @(negedge clk);
        #8;
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s actual=%h expected=queue_item", "scoreboard", rd_data);
            end else begin
                check(rd_data, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'b11;
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = S_CTRL; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = '0;
    endtask

    task automatic rd_with_abort(input logic [31:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        rd_en = 1'b1; rd_sel = S_OPND;
        wr_en = 1'b1; wr_sel = S_CTRL; wr_data = 32'h1;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'b11;
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = '0;
    endtask

    task automatic load_pattern(input logic [31:0] seed);
        @(negedge clk);
        for (int i = 0; i < NW; i++) begin
            pat[i] = seed ^ (32'h0101_0101 * (i + 1));
            test_data[32*i +: 32] = pat[i];
        end
        test_load = 1'b1;
        @(negedge clk);
        test_load = 1'b0;
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        busy_in = b;
    endtask

    task automatic z_save(input logic [31:0] exp, input string req);
        @(negedge clk);
        z_rd_en = 1'b1; z_rd_sel = S_SAVE;
        #8;
        check(z_rd_data, exp, req);
        @(negedge clk);
        z_rd_en = 1'b0; z_rd_sel = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check({31'h0, idle}, 32'h1, "R1 idle");
        check({31'h0, suspend_req}, 32'h0, "R1 suspend_req");

        // R11 load, R8 operand read while idle
        load_pattern(32'hA5C3_0F00);
        rd(S_OPND, 32'h0, "R8 idle operand read");
        check({31'h0, idle}, 32'h1, "R8 state unchanged");

        // R3 save not busy, R4 words, R9 save mid-transfer, R5 idle after last
        rd(S_SAVE, FMT_VALID, "R3 format word");
        check({31'h0, idle}, 32'h0, "R3 transfer started");
        rd(S_OPND, pat[0], "R4 word0 R11");
        rd(S_OPND, pat[1], "R4 word1");
        rd(S_SAVE, FMT_VALID, "R9 format again");
        rd(S_OPND, pat[2], "R9 position kept");
        check({31'h0, idle}, 32'h0, "R5 not idle before last");
        rd(S_OPND, pat[3], "R4 word3");
        check({31'h0, idle}, 32'h1, "R5 idle after last");
        rd(S_OPND, 32'h0, "R8 after transfer");

        // R2 busy: not-ready repeatedly, suspend request
        set_busy(1'b1);
        rd(S_SAVE, FMT_NR, "R2 not ready");
        check({31'h0, suspend_req}, 32'h1, "R2 suspend_req");
        check({31'h0, idle}, 32'h0, "R2 not idle");
        rd(S_OPND, 32'h0, "R8 operand during suspend");
        check({31'h0, suspend_req}, 32'h1, "R8 suspend kept");
        for (int k = 0; k < 3; k++) rd(S_SAVE, FMT_NR, "R2 still not ready");
        repeat (5) @(negedge clk);
        rd(S_SAVE, FMT_NR, "R2 long busy");
        set_busy(1'b0);
        rd(S_SAVE, FMT_VALID, "R3 format after busy");
        check({31'h0, suspend_req}, 32'h0, "R3 suspend cleared");

        // R7 control write without abort bit
        wr_ctrl(32'hFFFF_FFFE);
        check({31'h0, idle}, 32'h0, "R7 no abort");
        for (int i = 0; i < NW; i++) rd(S_OPND, pat[i], "R7 transfer continues");
        check({31'h0, idle}, 32'h1, "R5 idle after full transfer");

        // R6 abort mid-transfer
        load_pattern(32'h3C5A_9600);
        rd(S_SAVE, FMT_VALID, "R3 format");
        rd(S_OPND, pat[0], "R11 reloaded word0");
        wr_ctrl(32'h0000_0001);
        check({31'h0, idle}, 32'h1, "R6 abort to idle");
        rd(S_OPND, 32'h0, "R6 operand after abort");

        // R6 abort during suspend
        set_busy(1'b1);
        rd(S_SAVE, FMT_NR, "R2 not ready");
        wr_ctrl(32'h0000_0001);
        check({31'h0, idle}, 32'h1, "R6 abort from suspend idle");
        check({31'h0, suspend_req}, 32'h0, "R6 abort from suspend req");
        set_busy(1'b0);

        // R6 abort and operand read in the same cycle
        rd(S_SAVE, FMT_VALID, "R3 format");
        rd(S_OPND, pat[0], "R4 word0");
        rd_with_abort(pat[1], "R6 collision read");
        check({31'h0, idle}, 32'h1, "R6 collision idle");
        rd(S_SAVE, FMT_VALID, "R6 fresh save");
        rd(S_OPND, pat[0], "R6 restarts at word0");
        wr_ctrl(32'h0000_0001);

        // R10 zero-size configuration
        z_save(32'h0, "R10 empty format");
        check({31'h0, z_idle}, 32'h1, "R10 idle");
        @(negedge clk);
        z_busy = 1'b1;
        z_save(32'h0100_0000, "R2 zero-size not ready");
        @(negedge clk);
        z_busy = 1'b0;
        z_save(32'h0, "R10 empty after busy");
        check({31'h0, z_idle}, 32'h1, "R10 back to idle");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule